// File: doc/BRIEF.md
# Interrupt Status Collector for a Card Host Controller

This unit gathers single-cycle event pulses produced by the command, data, FIFO and card-detect paths of a card host controller. Each pulse lands in a sticky raw status register. Software clears raw bits by writing ones to them. A mask register selects which raw bits are allowed to reach the interrupt line. The masked view drives one interrupt output, and that output is further gated by a global enable input.

Two summary outputs report whether any enabled error event or any enabled completion event is pending. The unit also tracks one ordering rule. A response timeout is reported before the command-done event of the same command arrives, so the error cannot be treated as final until command-done is also present. A pending-timeout flag and a final-error output expose this rule, so the handler only finishes a request once both events have arrived.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the raw status is zero, the mask equals the parameter MASK_RST (default zero), and irq_o, error_any_o, done_any_o and err_final_o are all 0.
- R2: An event pulse on an implemented bit sets the raw bit in the next cycle. The bit then stays set until it is cleared. Implemented bits are 1 to 16, 30 and 31, where 2 is command done and 8 is response timeout.
- R3: Event pulses on unimplemented bits (0 and 17 to 29) are ignored, and those raw bits always read 0.
- R4: A clear write with a 1 in a bit position clears that raw bit in the next cycle. Positions written with 0 keep their value.
- R5: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: A mask write loads the mask in the next cycle, and masked_o always equals raw status AND mask.
- R7: irq_o is 1 exactly when at least one masked bit is set and irq_en_i is 1. It follows irq_en_i in the same cycle.
- R8: error_any_o is 1 exactly when a masked bit of the error group is set. The error group is bits 1, 6, 7, 8, 9, 11, 12, 13 and 15.
- R9: done_any_o is 1 exactly when a masked bit of the completion group is set. The completion group is bits 2, 3, 10 and 14.
- R10: timeout_pending_o is 1 when raw bit 8 is set while raw bit 2 is clear. err_final_o equals error_any_o AND NOT timeout_pending_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Single-cycle event pulses, one per status bit |
| clr_we_i | input | 1 | Write strobe for write-one-to-clear |
| clr_data_i | input | 32 | Bits to clear in the raw status |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_data_i | input | 32 | New mask value |
| irq_en_i | input | 1 | Global interrupt enable |
| raw_o | output | 32 | Raw status register |
| mask_o | output | 32 | Mask register |
| masked_o | output | 32 | Raw status AND mask |
| irq_o | output | 1 | Interrupt line |
| error_any_o | output | 1 | Some masked error-group bit is set |
| done_any_o | output | 1 | Some masked completion-group bit is set |
| timeout_pending_o | output | 1 | Response timeout seen, command done not yet seen |
| err_final_o | output | 1 | Error summary, held back while a timeout is pending |

## Verification
The bench builds the unit with MASK_RST left at zero. The reset check therefore sees a silent interrupt line, and every mask value afterwards comes from a write the bench makes itself. Starting from an empty mask puts the masking corners within reach: a fully masked status with the enable high, a single unmasked completion bit next to a masked error bit, and both summary groups read in isolation. Under a full mask the timeout ordering can be followed step by step, from the timeout alone to the arrival of command done.

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit #(
  parameter logic [31:0] MASK_RST = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic        clr_we_i,
  input  logic [31:0] clr_data_i,
  input  logic        mask_we_i,
  input  logic [31:0] mask_data_i,
  input  logic        irq_en_i,
  output logic [31:0] raw_o,
  output logic [31:0] mask_o,
  output logic [31:0] masked_o,
  output logic        irq_o,
  output logic        error_any_o,
  output logic        done_any_o,
  output logic        timeout_pending_o,
  output logic        err_final_o
);
  localparam logic [31:0] IMPL_BITS = 32'hC001_FFFE;
  localparam logic [31:0] ERR_GRP   = 32'h0000_BBC2;
  localparam logic [31:0] DONE_GRP  = 32'h0000_440C;
  localparam int          B_CMD_DONE = 2;
  localparam int          B_RSP_TO   = 8;

  logic [31:0] raw_q, mask_q, clr_vec, set_vec;

  assign clr_vec = clr_we_i ? clr_data_i : 32'h0;
  assign set_vec = evt_i & IMPL_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= 32'h0;
      mask_q <= MASK_RST;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | set_vec;
      if (mask_we_i) mask_q <= mask_data_i;
    end
  end

  assign raw_o             = raw_q;
  assign mask_o            = mask_q;
  assign masked_o          = raw_q & mask_q;
  assign irq_o             = irq_en_i & (|masked_o);
  assign error_any_o       = |(masked_o & ERR_GRP);
  assign done_any_o        = |(masked_o & DONE_GRP);
  assign timeout_pending_o = raw_q[B_RSP_TO] & ~raw_q[B_CMD_DONE];
  assign err_final_o       = error_any_o & ~timeout_pending_o;
endmodule

module irq_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic        clr_we_i,
  input logic [31:0] clr_data_i,
  input logic        mask_we_i,
  input logic [31:0] mask_data_i,
  input logic        irq_en_i,
  input logic [31:0] raw_o,
  input logic [31:0] mask_o,
  input logic [31:0] masked_o,
  input logic        irq_o,
  input logic        error_any_o,
  input logic        timeout_pending_o,
  input logic        err_final_o
);
  localparam logic [31:0] IMPL_BITS = 32'hC001_FFFE;

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_o & $past(evt_i & IMPL_BITS)) == $past(evt_i & IMPL_BITS)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((raw_o & $past(raw_o)) == $past(raw_o)));

  assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o & ~IMPL_BITS) == 32'h0);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((raw_o & $past(clr_data_i & ~evt_i)) == 32'h0));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_o == $past(mask_data_i)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_o));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_en_i && masked_o != 32'h0));

  assert_final_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_final_o |-> (!timeout_pending_o && error_any_o));
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (.*);

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;
  logic        clk = 0, rst_n = 0;
  logic [31:0] evt_i = 0, clr_data_i = 0, mask_data_i = 0;
  logic        clr_we_i = 0, mask_we_i = 0, irq_en_i = 0;
  logic [31:0] raw_o, mask_o, masked_o;
  logic        irq_o, error_any_o, done_any_o, timeout_pending_o, err_final_o;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_status_unit u_irq_status_unit (.*);

  // {event pulses, clear data (clear strobe = any bit set), expected raw}
  localparam logic [95:0] VEC [10] = '{
    {32'h0000_0004, 32'h0000_0000, 32'h0000_0004},  // R2 set
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0004},  // R2 sticky
    {32'h3FFE_0001, 32'h0000_0000, 32'h0000_0004},  // R3 ignored
    {32'hC000_0100, 32'h0000_0000, 32'hC000_0104},  // R2
    {32'h0000_0000, 32'h0000_0004, 32'hC000_0100},  // R4 partial clear
    {32'h0000_0100, 32'h0000_0100, 32'hC000_0100},  // R5 event wins
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 full clear
    {32'h0001_FFFE, 32'h0000_0000, 32'h0001_FFFE},  // R2 all low bits
    {32'h4000_0000, 32'h0001_FFFE, 32'h4000_0000},  // R4 + R2
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] ev, input logic cw, input logic [31:0] cd,
                     input logic mw, input logic [31:0] md);
    @(negedge clk);
    evt_i = ev; clr_we_i = cw; clr_data_i = cd; mask_we_i = mw; mask_data_i = md;
    @(posedge clk);
    @(negedge clk);
    evt_i = 0; clr_we_i = 0; clr_data_i = 0; mask_we_i = 0; mask_data_i = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R1 raw", raw_o, 0);
    chk("R1 mask", mask_o, 0);
    chk("R1 flags", {28'h0, irq_o, error_any_o, done_any_o, err_final_o}, 0);

    for (int i = 0; i < 10; i++) begin
      cyc(VEC[i][95:64], |VEC[i][63:32], VEC[i][63:32], 1'b0, 0);
      chk($sformatf("R2 R3 R4 R5 vector %0d", i), raw_o, VEC[i][31:0]);
    end

    // R6 R7 R8 R9: mask only command done, raise command done and response timeout
    cyc(0, 0, 0, 1, 32'h0000_0004);
    chk("R6 mask load", mask_o, 32'h0000_0004);
    cyc(32'h0000_0104, 0, 0, 0, 0);
    chk("R6 masked", masked_o, 32'h0000_0004);
    irq_en_i = 0; #1;
    chk("R7 irq disabled", {31'h0, irq_o}, 0);
    irq_en_i = 1; #1;
    chk("R7 irq enabled", {31'h0, irq_o}, 1);
    chk("R9 done_any", {31'h0, done_any_o}, 1);
    chk("R8 masked error hidden", {31'h0, error_any_o}, 0);
    chk("R10 no pending with cmd done", {31'h0, timeout_pending_o}, 0);
    cyc(0, 0, 0, 1, 32'h0);
    chk("R7 fully masked", {31'h0, irq_o}, 0);

    // R10 ordering under full mask
    cyc(0, 1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF);
    cyc(32'h0000_0100, 0, 0, 0, 0);
    chk("R8 timeout is error", {31'h0, error_any_o}, 1);
    chk("R10 pending", {31'h0, timeout_pending_o}, 1);
    chk("R10 final held", {31'h0, err_final_o}, 0);
    cyc(32'h0000_0004, 0, 0, 0, 0);
    chk("R10 pending released", {31'h0, timeout_pending_o}, 0);
    chk("R10 final", {31'h0, err_final_o}, 1);

    // R8 R9 single-group events
    cyc(0, 1, 32'hFFFF_FFFF, 0, 0);
    cyc(32'h0000_8000, 0, 0, 0, 0);
    chk("R8 end-bit error", {30'h0, error_any_o, done_any_o}, 2'b10);
    cyc(32'h0000_4000, 1, 32'h0000_8000, 0, 0);
    chk("R9 auto-command done", {30'h0, error_any_o, done_any_o}, 2'b01);
    cyc(32'h4000_0000, 1, 32'hFFFF_FFFF, 0, 0);
    chk("R8 R9 card insert in neither group", {29'h0, irq_o, error_any_o, done_any_o}, 3'b100);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule